// File: doc/BRIEF.md
# Beat-Tag Phase Error Calculator

This block sits behind a dual-mixer time-difference front end and turns the tags it delivers into the two error terms that a software or hardware PI loop needs to steer a local oscillator. A tag is the free-running beat counter value latched at a beat edge. Reference tags and main-clock tags arrive independently, each with a one-cycle valid strobe. The block stores the latest tag of each kind and raises a per-kind ready flag. Once both flags are up, it computes one pair of results and drops both flags.

Both results are taken modulo the beat period of 2^15 counts. The period error is the negated reference tag. The phase error is the main tag minus the reference tag minus a skew-calibration offset. The offset moves the sampling point of the recovered clock so that the downstream synchronizer meets its setup and hold windows. Each modular result is folded into a signed range centred on zero. The offset has a reset value chosen by a parameter for the reference source, and it can be read and rewritten at run time.

A two-state machine controls the sequencing. `ST_WAIT` holds until both ready flags are set. The transition `WAIT->EMIT` registers both results and clears the flags. `ST_EMIT` drives the one-cycle valid pulse. The transition `EMIT->WAIT` is unconditional.

Top module: `tag_phase_error`

## Requirements
- R1: After reset, `err_valid` is 0 and both error outputs are 0. `offset_q` is 19050 when `REF_IS_CDR` is 1 and 0 when it is 0.
- R2: A strobe on `ref_valid` or `main_valid` stores that tag and sets its ready flag. No result is produced while only one of the two flags is set.
- R3: When both flags are set at a clock edge, `err_valid` is 1 for exactly one cycle, in the cycle that follows that edge, and both flags are cleared at that edge.
- R4: `period_err` is (−ref_tag) mod 32768, after folding by R6.
- R5: `phase_err` is (main_tag − ref_tag − offset) mod 32768, after folding by R6, using the offset held at the compute edge.
- R6: Folding maps a modular value r ≥ 16384 to r − 32768, so every result lies in −16384..16383. As examples, ref_tag 0x4000 gives period_err −16384 and ref_tag 0x4001 gives 16383.
- R7: `offset_we` loads `offset_wdata` into the offset. The new value appears on `offset_q` after the next edge. A compute on that same edge still uses the previous offset.
- R8: A second tag of the same kind that arrives before a compute replaces the first, and the compute uses the latest one.
- R9: A tag strobe on the same edge as a compute is kept, and its ready flag stays set for the next compute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | Reference tag strobe |
| ref_tag | input | TAG_W | Reference tag value |
| main_valid | input | 1 | Main-clock tag strobe |
| main_tag | input | TAG_W | Main-clock tag value |
| offset_we | input | 1 | Offset write enable |
| offset_wdata | input | PER_LOG2 | New offset value |
| offset_q | output | PER_LOG2 | Current offset |
| err_valid | output | 1 | One-cycle result strobe |
| period_err | output | ERR_W | Signed period error |
| phase_err | output | ERR_W | Signed phase error |

## Verification
The bench builds two copies of the block. The main copy uses the defaults: 32-bit tags, a 2^15 beat period, 16-bit errors and the recovered-clock offset reset. It carries all traffic, including tags whose upper bits lie above the period and values that land exactly on the fold boundary. A second copy with `REF_IS_CDR` set to 0 is used only to check the alternative reset offset. The default widths bring within reach the wrap of the subtraction below zero and tags larger than the period.

// File: rtl/phase_err_pkg.sv
package phase_err_pkg;
    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_EMIT = 1'b1
    } calc_state_t;

    localparam int unsigned CDR_OFFSET_RST = 19050;
    localparam int unsigned EXT_OFFSET_RST = 0;
endpackage

// File: rtl/tag_latch.sv
module tag_latch #(
    parameter int TAG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             clear,
    output logic [TAG_W-1:0] tag_q,
    output logic             ready
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q <= '0;
            ready <= 1'b0;
        end else begin
            if (strobe) begin
                tag_q <= tag_in;       // R8: latest tag wins
                ready <= 1'b1;         // R9: new strobe beats clear
            end else if (clear) begin
                ready <= 1'b0;
            end
        end
    end

    a_r3_clear_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !strobe) |=> !ready);
    a_r9_strobe_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (ready && tag_q == $past(tag_in)));
endmodule

// File: rtl/skew_offset_reg.sv
module skew_offset_reg #(
    parameter int PER_LOG2 = 15,
    parameter bit REF_IS_CDR = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [PER_LOG2-1:0] wdata,
    output logic [PER_LOG2-1:0] offset
);
    import phase_err_pkg::*;

    localparam int unsigned RST_INT = REF_IS_CDR ? CDR_OFFSET_RST : EXT_OFFSET_RST;
    localparam logic [PER_LOG2-1:0] RST_VAL = RST_INT[PER_LOG2-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) offset <= RST_VAL;
        else if (we) offset <= wdata;
    end

    a_r7_offset_load: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> offset == $past(wdata));
    a_r7_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(offset));
endmodule

// File: rtl/err_fsm.sv
module err_fsm #(
    parameter int TAG_W    = 32,
    parameter int PER_LOG2 = 15,
    parameter int ERR_W    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_ready,
    input  logic                    main_ready,
    input  logic [TAG_W-1:0]        ref_tag,
    input  logic [TAG_W-1:0]        main_tag,
    input  logic [PER_LOG2-1:0]     offset,
    output logic                    clear,
    output logic                    err_valid,
    output logic signed [ERR_W-1:0] period_err,
    output logic signed [ERR_W-1:0] phase_err
);
    import phase_err_pkg::*;

    localparam int EXT_W = ERR_W - PER_LOG2;

    calc_state_t state_q, state_d;
    logic both_ready;
    logic [PER_LOG2-1:0] per_mod, pha_mod;

    // Fold a residue modulo 2^PER_LOG2 into the signed half-period range (R6)
    function automatic logic signed [ERR_W-1:0] fold(input logic [PER_LOG2-1:0] r);
        return {{EXT_W{r[PER_LOG2-1]}}, r};
    endfunction

    assign both_ready = ref_ready && main_ready;
    assign per_mod = '0 - ref_tag[PER_LOG2-1:0];                                   // R4
    assign pha_mod = main_tag[PER_LOG2-1:0] - ref_tag[PER_LOG2-1:0] - offset;     // R5

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_err <= '0;
            phase_err  <= '0;
        end else if (state_q == ST_WAIT && both_ready) begin
            period_err <= fold(per_mod);
            phase_err  <= fold(pha_mod);
        end
    end

    always_comb begin
        state_d   = state_q;
        clear     = 1'b0;
        err_valid = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (both_ready) begin
                    clear   = 1'b1;
                    state_d = ST_EMIT;
                end
            end
            ST_EMIT: begin
                err_valid = 1'b1;
                state_d   = ST_WAIT;
            end
        endcase
    end

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid);
    a_r2_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_valid) |-> $past(both_ready));
    a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (period_err >= -(2 ** (PER_LOG2 - 1)) && period_err < 2 ** (PER_LOG2 - 1)
                    && phase_err >= -(2 ** (PER_LOG2 - 1)) && phase_err < 2 ** (PER_LOG2 - 1)));
endmodule

// File: rtl/tag_phase_error.sv
module tag_phase_error #(
    parameter int TAG_W      = 32,
    parameter int PER_LOG2   = 15,
    parameter int ERR_W      = 16,
    parameter bit REF_IS_CDR = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_valid,
    input  logic [TAG_W-1:0]        ref_tag,
    input  logic                    main_valid,
    input  logic [TAG_W-1:0]        main_tag,
    input  logic                    offset_we,
    input  logic [PER_LOG2-1:0]     offset_wdata,
    output logic [PER_LOG2-1:0]     offset_q,
    output logic                    err_valid,
    output logic signed [ERR_W-1:0] period_err,
    output logic signed [ERR_W-1:0] phase_err
);
    logic             clear;
    logic             ref_rdy, main_rdy;
    logic [TAG_W-1:0] ref_q, main_q;

    tag_latch #(.TAG_W(TAG_W)) u_ref (
        .clk(clk), .rst_n(rst_n), .strobe(ref_valid), .tag_in(ref_tag),
        .clear(clear), .tag_q(ref_q), .ready(ref_rdy)
    );

    tag_latch #(.TAG_W(TAG_W)) u_main (
        .clk(clk), .rst_n(rst_n), .strobe(main_valid), .tag_in(main_tag),
        .clear(clear), .tag_q(main_q), .ready(main_rdy)
    );

    skew_offset_reg #(.PER_LOG2(PER_LOG2), .REF_IS_CDR(REF_IS_CDR)) u_off (
        .clk(clk), .rst_n(rst_n), .we(offset_we), .wdata(offset_wdata), .offset(offset_q)
    );

    err_fsm #(.TAG_W(TAG_W), .PER_LOG2(PER_LOG2), .ERR_W(ERR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ref_ready(ref_rdy), .main_ready(main_rdy),
        .ref_tag(ref_q), .main_tag(main_q), .offset(offset_q), .clear(clear),
        .err_valid(err_valid), .period_err(period_err), .phase_err(phase_err)
    );

    a_r3_clear_on_compute: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !ref_valid && !main_valid) |=> (!ref_rdy && !main_rdy && err_valid));
endmodule

// File: tb/tb_tag_phase_error.sv
module tb_tag_phase_error;
    localparam int TAG_W = 32;
    localparam int PL = 15;
    localparam int EW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_valid = 1'b0, main_valid = 1'b0, offset_we = 1'b0;
    logic [TAG_W-1:0] ref_tag = '0, main_tag = '0;
    logic [PL-1:0] offset_wdata = '0;
    logic [PL-1:0] offset_q, offset_q2;
    logic err_valid, err_valid2;
    logic signed [EW-1:0] period_err, phase_err, period_err2, phase_err2;

    int n_chk = 0;
    int n_bad = 0;
    int off_m = 19050;
    logic signed [EW-1:0] q_per[$];
    logic signed [EW-1:0] q_pha[$];
    string q_tag[$];

    always #4 clk = ~clk;

    tag_phase_error dut (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_tag(ref_tag),
        .main_valid(main_valid), .main_tag(main_tag), .offset_we(offset_we),
        .offset_wdata(offset_wdata), .offset_q(offset_q), .err_valid(err_valid),
        .period_err(period_err), .phase_err(phase_err)
    );

    tag_phase_error #(.REF_IS_CDR(1'b0)) dut_ext (
        .clk(clk), .rst_n(rst_n), .ref_valid(1'b0), .ref_tag('0),
        .main_valid(1'b0), .main_tag('0), .offset_we(1'b0),
        .offset_wdata('0), .offset_q(offset_q2), .err_valid(err_valid2),
        .period_err(period_err2), .phase_err(phase_err2)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic signed [EW-1:0] fold_m(input longint v);
        longint r;
        r = ((v % 32768) + 32768) % 32768;
        if (r >= 16384) r = r - 32768;
        return EW'(r);
    endfunction

    task automatic expect_pair(input longint r, input longint m, input int off, input string req);
        q_per.push_back(fold_m(-r));
        q_pha.push_back(fold_m(m - r - off));
        q_tag.push_back(req);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && err_valid) begin
            if (q_per.size() == 0) begin
                check(1'b0, "R2 unexpected result", 1, 0);
            end else begin
                logic signed [EW-1:0] ep, eh;
                string t;
                ep = q_per.pop_front();
                eh = q_pha.pop_front();
                t = q_tag.pop_front();
                check(period_err == ep, {t, " R4 period"}, period_err, ep);
                check(phase_err == eh, {t, " R5 phase"}, phase_err, eh);
            end
        end
    end

    task automatic pulse_both(input logic [TAG_W-1:0] r, input logic [TAG_W-1:0] m, input string req);
        @(negedge clk);
        ref_valid = 1'b1; ref_tag = r; main_valid = 1'b1; main_tag = m;
        expect_pair(longint'(r), longint'(m), off_m, req);
        @(negedge clk);
        ref_valid = 1'b0; main_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic write_off(input int v);
        @(negedge clk);
        offset_we = 1'b1; offset_wdata = PL'(v);
        @(negedge clk);
        offset_we = 1'b0;
        off_m = v;
        check(offset_q == PL'(v), "R7 offset readback", offset_q, v);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        // R1 reset state
        check(err_valid == 1'b0, "R1 valid", err_valid, 0);
        check(period_err == 0, "R1 period", period_err, 0);
        check(phase_err == 0, "R1 phase", phase_err, 0);
        check(offset_q == 19050, "R1 cdr offset", offset_q, 19050);
        check(offset_q2 == 0, "R1 ext offset", offset_q2, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);

        // R3 timing: drive at n0, flags set at E0, compute at E1
        ref_valid = 1'b1; ref_tag = 32'd100; main_valid = 1'b1; main_tag = 32'd20000;
        expect_pair(100, 20000, off_m, "R3");
        @(negedge clk);
        ref_valid = 1'b0; main_valid = 1'b0;
        check(err_valid == 1'b0, "R3 not yet", err_valid, 0);
        @(negedge clk);
        check(err_valid == 1'b1, "R3 pulse", err_valid, 1);
        @(negedge clk);
        check(err_valid == 1'b0, "R3 one cycle", err_valid, 0);
        repeat (2) @(negedge clk);

        // R2 single tag yields nothing
        ref_valid = 1'b1; ref_tag = 32'd5;
        @(negedge clk) ref_valid = 1'b0;
        repeat (5) begin
            @(negedge clk);
            check(err_valid == 1'b0, "R2 one flag only", err_valid, 0);
        end
        // R8 newer ref replaces older one
        ref_valid = 1'b1; ref_tag = 32'd777;
        @(negedge clk) ref_valid = 1'b0;
        repeat (2) @(negedge clk);
        main_valid = 1'b1; main_tag = 32'd1234;
        expect_pair(777, 1234, off_m, "R8");
        @(negedge clk) main_valid = 1'b0;
        repeat (4) @(negedge clk);

        // R6 fold boundaries
        pulse_both(32'h0000_4000, 32'h0000_4000 + 32'd19050 + 32'h4000, "R6 lo");
        pulse_both(32'h0000_4001, 32'h0000_4001 + 32'd19050 + 32'h3FFF, "R6 hi");
        pulse_both(32'd0, 32'd19050, "R6 zero");
        // R4/R5 large tags and wrap below zero
        pulse_both(32'hDEAD_BEEF, 32'h0000_0003, "R5 wrap");
        for (int i = 0; i < 20; i++)
            pulse_both($urandom, $urandom, "R4 random");

        // R7 offset write, then use
        write_off(12345);
        pulse_both(32'd1000, 32'd900, "R7 new offset");
        // R7 write on compute edge uses old offset
        @(negedge clk);
        ref_valid = 1'b1; ref_tag = 32'd50; main_valid = 1'b1; main_tag = 32'd60;
        expect_pair(50, 60, off_m, "R7 same edge");
        @(negedge clk);
        ref_valid = 1'b0; main_valid = 1'b0;
        offset_we = 1'b1; offset_wdata = PL'(0);
        @(negedge clk);
        offset_we = 1'b0; off_m = 0;
        check(offset_q == 0, "R7 readback", offset_q, 0);
        repeat (3) @(negedge clk);

        // R9 ref strobe on compute edge is kept
        ref_valid = 1'b1; ref_tag = 32'd300; main_valid = 1'b1; main_tag = 32'd400;
        expect_pair(300, 400, off_m, "R9 first");
        @(negedge clk);
        main_valid = 1'b0; ref_tag = 32'd9000;   // ref strobe during compute edge
        @(negedge clk);
        ref_valid = 1'b0;
        repeat (4) @(negedge clk);
        main_valid = 1'b1; main_tag = 32'd100;
        expect_pair(9000, 100, off_m, "R9 kept");
        @(negedge clk) main_valid = 1'b0;
        repeat (5) @(negedge clk);

        check(q_per.size() == 0, "R3 all results seen", q_per.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule